// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer with Host Read Port

This block holds the digital side of an 8-bit successive-approximation converter that sits on a microprocessor bus. It drives a trial code to an external DAC and samples one comparator bit per cycle. It steps the code from the most significant bit down to the least significant bit and places the finished result in an output latch. It also raises a hold strobe for an external track/hold, drives an active-low busy line, and presents the latch on a data bus whose three-state enable is asserted only while the host selects it.

The host starts a conversion by driving chip-select and read low together. In slow-memory use the host keeps both low until busy returns high and then takes the fresh result. In ROM-style use the host issues a short read, gets the previous result, and the same read starts the next conversion. A read whose falling select is sampled on the clock edge right after busy rises returns data without starting a conversion. When the free-run input is low, conversions repeat on their own and reads only fetch the latch.

All timing is counted in rising edges of the single clock `clk`. The "start edge" is the first edge at which chip-select and read are both sampled low after a sample in which they were not both low.

Top module: `sar_adc_ctl`

## Requirements
- R1: While no conversion is running, and at the first comparison of every conversion, `dac_code_o` equals half scale, 0x80.
- R2: `comp_i` = 1 means the held input is at or above the current trial code. At each comparison the trial bit is kept when `comp_i` is 1 and cleared when it is 0. The next lower bit is then set, and the new code appears on `dac_code_o` after that edge.
- R3: A conversion makes exactly eight comparisons, MSB first, on the 4th to 11th edges counted from the start edge as the 1st. At the 11th edge the final code is copied into the latch. `data_o` always shows the latch and changes at no other time.
- R4: `busy_n_o` goes low after the start edge and returns high after the 11th edge, which is the same edge that updates the latch. It is therefore low for exactly 10 cycles.
- R5: After the edge that ends a conversion, `dac_code_o` is 0x80 again.
- R6: `data_oe_o` is 1 exactly while `cs_n` and `rd_n` are both 0.
- R7: `hold_o` rises after the 3rd edge, counted from the start edge, and falls after the edge that ends the conversion. It is high only while busy is low.
- R8: In slow-memory use, a select held low through a whole conversion does not start another one. `data_o` shows the new result once busy is high.
- R9: A short read while idle returns the previous result and starts a new conversion.
- R10: If the start edge falls on the edge right after the one at which busy rose, the read returns data but no conversion starts.
- R11: A select that falls while a conversion is running neither alters nor restarts it.
- R12: With `free_run_n` = 0, conversions start by themselves, with busy high for one cycle between them. Reads only return the latch.
- R13: Synchronous `rst` = 1 sets busy high, hold low, the latch to 0x00 and the DAC code to 0x80. Reads during reset return the latch. A select that is still low when reset ends starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion and interface clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip-select, active low |
| rd_n | input | 1 | Read strobe, active low |
| free_run_n | input | 1 | 0 = continuous conversions, 1 = bus-started conversions |
| comp_i | input | 1 | Comparator: 1 when held input >= trial code |
| dac_code_o | output | 8 | Trial code for the external DAC |
| hold_o | output | 1 | Track/hold strobe, 1 = hold |
| busy_n_o | output | 1 | Conversion in progress, active low |
| data_o | output | 8 | Latched result for the host bus |
| data_oe_o | output | 1 | Three-state enable for data_o |

## Verification
A wrong bit decision or a misplaced bit index appears on `dac_code_o` at the very next edge, and the reference model compares that code every cycle. It also reaches `data_o` when the conversion ends. A sequencer stuck in the wrong phase shows up within one cycle as a busy or hold level that differs from the model, or as a busy-low time other than 10 cycles. A missing or misplaced one-cycle guard turns into an extra busy-low pulse right after a conversion ends.

// File: rtl/sar_ctl_pkg.sv
package sar_ctl_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ACQ  = 2'd1,
        PH_CONV = 2'd2
    } phase_e;

endpackage

// File: rtl/sar_bus_port.sv
module sar_bus_port #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic [WIDTH-1:0] latch_i,
    output logic             sel_fall_o,
    output logic [WIDTH-1:0] data_o,
    output logic             data_oe_o
);

    typedef struct packed {
        logic sel_prev;
    } port_state_t;

    port_state_t port_d, port_q;
    logic        sel_now;

    always_comb begin
        sel_now         = ~cs_n & ~rd_n;
        port_d          = port_q;
        port_d.sel_prev = sel_now;
        sel_fall_o      = sel_now & ~port_q.sel_prev;
        data_o          = latch_i;
        data_oe_o       = sel_now;
    end

    // The previous select is sampled during reset as well, so a select
    // held low across reset release does not look like a new request.
    always_ff @(posedge clk) begin
        port_q <= port_d;
    end

endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
    import sar_ctl_pkg::*;
#(
    parameter int WIDTH     = 8,
    parameter int ACQ_EDGES = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      sel_fall_i,
    input  logic                      free_run_n,
    output logic                      busy_n_o,
    output logic                      hold_o,
    output logic                      cmp_en_o,
    output logic                      done_o,
    output logic [$clog2(WIDTH)-1:0]  bit_idx_o
);

    localparam int IW = $clog2(WIDTH);
    localparam int CW = $clog2(ACQ_EDGES + 1);
    localparam logic [CW-1:0] ACQ_LAST = CW'(ACQ_EDGES - 1);
    localparam logic [IW-1:0] TOP_IDX  = IW'(WIDTH - 1);

    typedef struct packed {
        phase_e        ph;
        logic          busy_n;
        logic          hold;
        logic          guard;
        logic [IW-1:0] idx;
        logic [CW-1:0] cnt;
    } seq_state_t;

    seq_state_t seq_d, seq_q;
    logic       start_req;

    always_comb begin
        seq_d       = seq_q;
        seq_d.guard = 1'b0;
        cmp_en_o    = 1'b0;
        done_o      = 1'b0;
        // In free-run the guard window does not apply.
        start_req   = free_run_n ? (sel_fall_i & ~seq_q.guard) : 1'b1;

        unique case (seq_q.ph)
            PH_IDLE: begin
                if (start_req) begin
                    seq_d.ph     = PH_ACQ;
                    seq_d.busy_n = 1'b0;
                    seq_d.cnt    = CW'(1);
                end
            end
            PH_ACQ: begin
                if (seq_q.cnt == ACQ_LAST) begin
                    seq_d.hold = 1'b1;
                    seq_d.ph   = PH_CONV;
                    seq_d.idx  = TOP_IDX;
                end else begin
                    seq_d.cnt = seq_q.cnt + CW'(1);
                end
            end
            PH_CONV: begin
                cmp_en_o = 1'b1;
                if (seq_q.idx == '0) begin
                    done_o       = 1'b1;
                    seq_d.ph     = PH_IDLE;
                    seq_d.busy_n = 1'b1;
                    seq_d.hold   = 1'b0;
                    seq_d.guard  = 1'b1;
                end else begin
                    seq_d.idx = seq_q.idx - IW'(1);
                end
            end
            default: seq_d.ph = PH_IDLE;
        endcase

        busy_n_o  = seq_q.busy_n;
        hold_o    = seq_q.hold;
        bit_idx_o = seq_q.idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.ph     <= PH_IDLE;
            seq_q.busy_n <= 1'b1;
            seq_q.hold   <= 1'b0;
            seq_q.guard  <= 1'b0;
            seq_q.idx    <= '0;
            seq_q.cnt    <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    // R4: an accepted request pulls busy low on the next cycle
    p_start_busy_r4: assert property (@(posedge clk) disable iff (rst)
        (seq_q.ph == PH_IDLE && start_req) |=> !busy_n_o);

    // R7: the finishing comparison releases hold and busy together
    p_end_release_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (busy_n_o && !hold_o));

    // R7: hold is never up outside a conversion
    p_hold_in_busy_r7: assert property (@(posedge clk) disable iff (rst)
        hold_o |-> !busy_n_o);

    // R10: a request right after busy rises is refused
    p_guard_r10: assert property (@(posedge clk) disable iff (rst)
        (seq_q.guard && free_run_n) |=> busy_n_o);

endmodule

// File: rtl/sar_register.sv
module sar_register #(
    parameter int WIDTH = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cmp_en_i,
    input  logic                     done_i,
    input  logic [$clog2(WIDTH)-1:0] bit_idx_i,
    input  logic                     comp_i,
    output logic [WIDTH-1:0]         dac_code_o,
    output logic [WIDTH-1:0]         latch_o
);

    localparam int IW = $clog2(WIDTH);
    localparam logic [WIDTH-1:0] HALF = WIDTH'(1) << (WIDTH - 1);

    typedef struct packed {
        logic [WIDTH-1:0] code;
        logic [WIDTH-1:0] latch;
    } sar_state_t;

    sar_state_t       sar_d, sar_q;
    logic [WIDTH-1:0] trial;
    logic [IW-1:0]    lower_idx;

    always_comb begin
        sar_d     = sar_q;
        trial     = sar_q.code;
        lower_idx = bit_idx_i - IW'(1);
        if (cmp_en_i) begin
            trial[bit_idx_i] = comp_i;
            if (bit_idx_i != '0) begin
                trial[lower_idx] = 1'b1;
            end
            if (done_i) begin
                sar_d.latch = trial;
                sar_d.code  = HALF;
            end else begin
                sar_d.code  = trial;
            end
        end
        dac_code_o = sar_q.code;
        latch_o    = sar_q.latch;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sar_q.code  <= HALF;
            sar_q.latch <= '0;
        end else begin
            sar_q <= sar_d;
        end
    end

    // R1: the first decision of a conversion is made against half scale
    p_first_trial_r1: assert property (@(posedge clk) disable iff (rst)
        (cmp_en_i && bit_idx_i == IW'(WIDTH - 1)) |-> dac_code_o == HALF);

    // R5: the code is back at half scale once a conversion has ended
    p_back_half_r5: assert property (@(posedge clk) disable iff (rst)
        done_i |=> dac_code_o == HALF);

endmodule

// File: rtl/sar_adc_ctl.sv
module sar_adc_ctl #(
    parameter int WIDTH     = 8,
    parameter int ACQ_EDGES = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             free_run_n,
    input  logic             comp_i,
    output logic [WIDTH-1:0] dac_code_o,
    output logic             hold_o,
    output logic             busy_n_o,
    output logic [WIDTH-1:0] data_o,
    output logic             data_oe_o
);

    localparam int IW = $clog2(WIDTH);
    localparam logic [WIDTH-1:0] HALF = WIDTH'(1) << (WIDTH - 1);

    logic             sel_fall;
    logic             cmp_en;
    logic             done;
    logic [IW-1:0]    bit_idx;
    logic [WIDTH-1:0] latch;

    sar_bus_port #(.WIDTH(WIDTH)) u_port (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .rd_n       (rd_n),
        .latch_i    (latch),
        .sel_fall_o (sel_fall),
        .data_o     (data_o),
        .data_oe_o  (data_oe_o)
    );

    sar_sequencer #(.WIDTH(WIDTH), .ACQ_EDGES(ACQ_EDGES)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .sel_fall_i (sel_fall),
        .free_run_n (free_run_n),
        .busy_n_o   (busy_n_o),
        .hold_o     (hold_o),
        .cmp_en_o   (cmp_en),
        .done_o     (done),
        .bit_idx_o  (bit_idx)
    );

    sar_register #(.WIDTH(WIDTH)) u_reg (
        .clk        (clk),
        .rst        (rst),
        .cmp_en_i   (cmp_en),
        .done_i     (done),
        .bit_idx_i  (bit_idx),
        .comp_i     (comp_i),
        .dac_code_o (dac_code_o),
        .latch_o    (latch)
    );

    // R3: the host-visible result moves only when busy rises
    p_data_steady_r3: assert property (@(posedge clk) disable iff (rst)
        (busy_n_o && $past(busy_n_o)) |-> $stable(data_o));

    // R13: reset leaves the block idle at half scale with a cleared latch
    p_reset_state_r13: assert property (@(posedge clk)
        rst |=> (busy_n_o && !hold_o && dac_code_o == HALF && data_o == '0));

endmodule

// File: tb/sar_adc_ctl_tb.sv
module sar_adc_ctl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       free_run_n = 1'b1;
    logic       comp;
    logic [7:0] dac_code_o;
    logic       hold_o;
    logic       busy_n_o;
    logic [7:0] data_o;
    logic       data_oe_o;

    int vin   = 0;
    int vheld = 0;
    int n_chk = 0;
    int n_bad = 0;
    int wd    = 0;

    always #5 clk = ~clk;

    sar_adc_ctl u_dut (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .rd_n       (rd_n),
        .free_run_n (free_run_n),
        .comp_i     (comp),
        .dac_code_o (dac_code_o),
        .hold_o     (hold_o),
        .busy_n_o   (busy_n_o),
        .data_o     (data_o),
        .data_oe_o  (data_oe_o)
    );

    // external track/hold and comparator
    always @(posedge clk) if (!hold_o) vheld <= vin;
    assign comp = (vheld >= int'(dac_code_o));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference, advanced on every rising edge
    bit m_en = 0, m_run = 0, m_busy = 1, m_hold = 0, m_guard = 0, m_selp = 0, m_sel;
    int m_age = 0, m_code = 128, m_latch = 0, m_held = 0, bp;

    always @(posedge clk) begin
        m_en  = 1;
        m_sel = !cs_n && !rd_n;
        if (rst) begin
            m_run = 0; m_busy = 1; m_hold = 0; m_guard = 0;
            m_code = 128; m_latch = 0;
        end else if (!m_run) begin
            if (!free_run_n || (m_sel && !m_selp && !m_guard)) begin
                m_run = 1; m_age = 1; m_busy = 0;
            end
            m_guard = 0;
        end else begin
            m_guard = 0;
            m_age++;
            if (m_age == 3) begin
                m_hold = 1; m_held = vin;
            end else if (m_age >= 4) begin
                bp = 11 - m_age;
                if (m_held < m_code) m_code = m_code & ~(1 << bp);
                if (bp > 0) m_code = m_code | (1 << (bp - 1));
                if (bp == 0) begin
                    m_latch = m_code; m_code = 128; m_busy = 1;
                    m_hold = 0; m_run = 0; m_guard = 1;
                end
            end
        end
        m_selp = m_sel;
    end

    always @(negedge clk) begin
        if (m_en) begin
            chk(busy_n_o === m_busy, "R4 busy", busy_n_o, m_busy);
            chk(hold_o === m_hold, "R7 hold", hold_o, m_hold);
            chk(dac_code_o === 8'(m_code), "R2 dac", dac_code_o, m_code);
            chk(data_o === 8'(m_latch), "R3 data", data_o, m_latch);
            chk(data_oe_o === (!cs_n && !rd_n), "R6 oe", data_oe_o, !cs_n && !rd_n);
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 20000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic drive_sel(input bit v);
        @(posedge clk); #1;
        cs_n = !v; rd_n = !v;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!busy_n_o) @(negedge clk);
    endtask

    task automatic count_busy(output int n);
        n = 0;
        @(posedge clk);
        @(negedge clk);
        while (!busy_n_o) begin n++; @(negedge clk); end
    endtask

    int nb, rises;

    initial begin
        // R13: reads during reset, select held through release
        cs_n = 0; rd_n = 0;
        repeat (3) @(negedge clk);
        chk(busy_n_o && !hold_o, "R13 busy/hold", {busy_n_o, hold_o}, 2'b10);
        chk(data_oe_o && data_o == 8'h00, "R13 read latch", data_o, 0);
        chk(dac_code_o == 8'h80, "R13 dac", dac_code_o, 8'h80);
        @(posedge clk); #1 rst = 0;
        repeat (4) @(negedge clk);
        chk(busy_n_o == 1, "R13 no start", busy_n_o, 1);
        drive_sel(0);

        // R8: slow-memory read held low for the whole conversion
        vin = 8'hA5;
        repeat (2) @(negedge clk);
        chk(dac_code_o == 8'h80, "R1 idle half", dac_code_o, 8'h80);
        drive_sel(1);
        count_busy(nb);
        chk(nb == 10, "R3 busy len", nb, 10);
        chk(data_o == 8'hA5, "R8 new data", data_o, 8'hA5);
        chk(dac_code_o == 8'h80, "R5 half again", dac_code_o, 8'h80);
        repeat (3) @(negedge clk);
        chk(busy_n_o == 1, "R8 no restart", busy_n_o, 1);
        drive_sel(0);

        // R9: ROM-style reads
        vin = 8'h3C;
        repeat (3) @(negedge clk);
        drive_sel(1);
        @(negedge clk);
        chk(data_oe_o && data_o == 8'hA5, "R9 old data", data_o, 8'hA5);
        drive_sel(0);
        wait_idle();
        repeat (3) @(negedge clk);
        drive_sel(1);
        @(negedge clk);
        chk(data_o == 8'h3C, "R9 fresh data", data_o, 8'h3C);
        @(negedge clk);
        chk(busy_n_o == 0, "R9 restarted", busy_n_o, 0);
        drive_sel(0);

        // R10: read right after busy rises
        vin = 8'h5A;
        wait_idle();
        repeat (2) @(negedge clk);
        drive_sel(1);
        drive_sel(0);
        @(negedge clk);
        while (!busy_n_o) @(negedge clk);
        #1 cs_n = 0; rd_n = 0;
        repeat (3) @(negedge clk);
        chk(busy_n_o == 1, "R10 no start", busy_n_o, 1);
        chk(data_oe_o && data_o == 8'h5A, "R10 data", data_o, 8'h5A);
        drive_sel(0);

        // R11: select falling mid-conversion
        vin = 8'h81;
        repeat (2) @(negedge clk);
        drive_sel(1);
        drive_sel(0);
        repeat (4) @(negedge clk);
        drive_sel(1);
        drive_sel(0);
        wait_idle();
        repeat (3) @(negedge clk);
        chk(busy_n_o == 1, "R11 no extra", busy_n_o, 1);
        chk(data_o == 8'h81, "R11 result", data_o, 8'h81);

        // R12: continuous conversions, extremes of the input range
        vin = 8'hFF;
        @(posedge clk); #1 free_run_n = 0;
        rises = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (busy_n_o) rises++;
        end
        chk(rises >= 2, "R12 repeats", rises, 2);
        drive_sel(1);
        @(negedge clk);
        chk(data_o == 8'hFF, "R12 full scale", data_o, 8'hFF);
        drive_sel(0);
        vin = 0;
        repeat (30) @(negedge clk);
        drive_sel(1);
        @(negedge clk);
        chk(data_o == 8'h00, "R2 zero code", data_o, 0);
        drive_sel(0);
        @(posedge clk); #1 free_run_n = 1;
        wait_idle();
        repeat (4) @(negedge clk);
        chk(busy_n_o == 1, "R12 stops", busy_n_o, 1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule